// File: doc/BRIEF.md
# Post-Increment Load/Store Unit

This unit executes the custom post-increment memory instructions of a 32-bit core. For each accepted instruction it takes the raw instruction word, the value of the base register, the value of an offset register and the value of a store source register. It decodes the operation and issues one memory request at the unmodified base address. Once the memory answers, it produces up to two register write-back candidates: the extended load result, and the base register advanced by a sign-extended immediate or by the offset register value.

Instructions arrive on a valid/ready stream. `in_ready` is high only while the unit is idle, so the producer must hold `in_valid` and the operands until a cycle with both high. The memory request is also valid/ready. Once `req_valid` rises, the unit holds it and every request field steady until `req_ready` is seen. Responses have no back-pressure: the unit always accepts `rsp_valid` while it waits for one. Write-back strobes are plain single-cycle pulses.

Top module: `pinc_postinc_lsu`

## Requirements
- R1: After reset, `busy`, `req_valid`, `err`, `wb_data_en` and `wb_addr_en` are low and `in_ready` is high.
- R2: Opcode 0001011 is an immediate-offset load whose kind is chosen by bits 14:12. The codes are 000 signed byte, 100 unsigned byte, 001 signed half, 101 unsigned half and 010 word. The offset is the sign-extended field in bits 31:20. The destination index is in bits 11:7 and the base index is in bits 19:15.
- R3: Opcode 0101011 with bits 14:12 = 011 is a register-offset load when bits 31:25 hold one of five codes. These are 0000000 signed byte, 0001000 unsigned byte, 0000001 signed half, 0001001 unsigned half and 0000010 word. The offset is the value on `in_offs`.
- R4: Opcode 0101011 with bits 14:12 equal to 000, 001 or 010 is an immediate-offset store of a byte, half or word. Its 12-bit offset is {bits 31:25, bits 11:7}, sign-extended. The data comes from `in_sdata`.
- R5: Opcode 0101011 with bits 14:12 = 011 and bits 31:25 equal to 0010000, 0010001 or 0010010 is a register-offset store of a byte, half or word. The offset is the value on `in_offs`; bits 11:7 name only that offset register and never a write-back target.
- R6: A request carries `req_addr` equal to the unmodified base and `req_we` high for stores only. `req_be` enables the bytes from lane base[1:0] upward, for the access size. For a store, `req_wdata` holds the source data shifted up by 8*base[1:0] bits on the enabled lanes.
- R7: The load result takes the response word shifted down by 8*base[1:0] bits. It sign-extends signed bytes and halves, zero-extends unsigned ones, and passes words unchanged.
- R8: After the response, `wb_addr_en` pulses for one cycle with `wb_addr_reg` equal to the base index and `wb_addr_val` equal to base plus offset (modulo 2^32). Loads also pulse `wb_data_en` with `wb_data_reg` equal to the destination index.
- R9: When a load's destination index equals its base index, only the load result is written back and `wb_addr_en` stays low.
- R10: An unknown encoding, a half access with base[0] set or a word access with base[1:0] nonzero raises `err` for exactly the cycle after acceptance. It issues no request and no write-back, and the unit stays idle.
- R11: `req_valid` rises the cycle after acceptance and holds steady until `req_ready`. `busy` is high and `in_ready` low from acceptance until the write-back cycle. The write-back pulses appear the cycle after `rsp_valid` is sampled in the waiting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_instr | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| in_offs | input | 32 | Offset register value (register-offset forms) |
| in_sdata | input | 32 | Store source register value |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory takes the request |
| req_addr | output | 32 | Access address (unmodified base) |
| req_we | output | 1 | High for a store |
| req_be | output | 4 | Byte lane enables |
| req_wdata | output | 32 | Lane-aligned store data |
| rsp_valid | input | 1 | Memory response valid |
| rsp_rdata | input | 32 | Response data word |
| wb_data_en | output | 1 | Load result write strobe |
| wb_data_reg | output | 5 | Load destination index |
| wb_data_val | output | 32 | Extended load result |
| wb_addr_en | output | 1 | Updated base write strobe |
| wb_addr_reg | output | 5 | Base register index |
| wb_addr_val | output | 32 | Base plus offset |
| busy | output | 1 | Request outstanding |
| err | output | 1 | Rejected instruction pulse |

## Verification
A wrong captured field shows at the request port one cycle after acceptance, as a wrong address, wrong lanes or wrong data. A wrong offset or extension shows one cycle after the response, as a wrong write-back value or index. A stuck control state shows immediately: `in_ready` stays low, `req_valid` does not rise, or a write-back pulse goes missing or repeats. The bench checks every one of these windows, cycle by cycle, against a behavioural memory model, with back-pressure and response delays.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int XLEN  = 32;
  localparam int REGW  = 5;
  localparam int NBYTE = XLEN / 8;
  localparam int LANEW = $clog2(NBYTE);
  localparam int IMMW  = 12;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} fsm_e;

  typedef struct packed {
    logic            legal;
    logic            store;
    logic            unsgn;
    acc_size_e       size;
    logic            use_reg;
    logic [REGW-1:0] rd;
    logic [REGW-1:0] rb;
    logic [XLEN-1:0] imm;
  } dec_t;
endpackage

// File: rtl/pinc_decode.sv
module pinc_decode
  import pinc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [6:0]      f7;
  logic [IMMW-1:0] ld_imm;
  logic [IMMW-1:0] st_imm;

  assign opc    = instr[6:0];
  assign f3     = instr[14:12];
  assign f7     = instr[31:25];
  assign ld_imm = instr[31:20];
  assign st_imm = {instr[31:25], instr[11:7]};

  always_comb begin
    dec      = '0;
    dec.size = SZ_B;
    dec.rb   = instr[19:15];
    dec.rd   = instr[11:7];
    if (opc == 7'b0001011) begin
      // immediate load: f3[2] unsigned, f3[1:0] size
      if (f3[1:0] != 2'b11 && !(f3[2] && f3[1])) begin
        dec.legal = 1'b1;
        dec.unsgn = f3[2];
        dec.size  = acc_size_e'(f3[1:0]);
        dec.imm   = {{(XLEN-IMMW){ld_imm[IMMW-1]}}, ld_imm};
      end
    end else if (opc == 7'b0101011) begin
      if (f3 == 3'b011) begin
        dec.use_reg = 1'b1;
        if (f7[6:4] == 3'b000 && !f7[2] && f7[1:0] != 2'b11 && !(f7[3] && f7[1])) begin
          dec.legal = 1'b1;
          dec.unsgn = f7[3];
          dec.size  = acc_size_e'(f7[1:0]);
        end else if (f7[6:2] == 5'b00100 && f7[1:0] != 2'b11) begin
          dec.legal = 1'b1;
          dec.store = 1'b1;
          dec.size  = acc_size_e'(f7[1:0]);
        end
      end else if (!f3[2] && f3[1:0] != 2'b11) begin
        dec.legal = 1'b1;
        dec.store = 1'b1;
        dec.size  = acc_size_e'(f3[1:0]);
        dec.imm   = {{(XLEN-IMMW){st_imm[IMMW-1]}}, st_imm};
      end
    end
  end
endmodule

// File: rtl/pinc_lane.sv
module pinc_lane
  import pinc_pkg::*;
(
  input  acc_size_e        size,
  input  logic [LANEW-1:0] ofs,
  input  logic [XLEN-1:0]  sdata,
  output logic [NBYTE-1:0] be,
  output logic [XLEN-1:0]  wdata,
  output logic             misal
);
  logic [LANEW:0]   nb;
  logic [LANEW:0]   nbm1;
  logic [LANEW+1:0] lim;

  assign nb    = (LANEW+1)'(1) << size;
  assign nbm1  = nb - (LANEW+1)'(1);
  assign lim   = (LANEW+2)'(ofs) + (LANEW+2)'(nb);
  assign misal = |(ofs & nbm1[LANEW-1:0]);
  assign wdata = sdata << {ofs, 3'b000};

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    assign be[g] = ((LANEW+2)'(g) >= (LANEW+2)'(ofs)) && ((LANEW+2)'(g) < lim);
  end
endmodule

// File: rtl/pinc_ldext.sv
module pinc_ldext
  import pinc_pkg::*;
(
  input  logic [XLEN-1:0]  rdata,
  input  logic [LANEW-1:0] ofs,
  input  acc_size_e        size,
  input  logic             unsgn,
  output logic [XLEN-1:0]  result
);
  logic [XLEN-1:0] shifted;

  assign shifted = rdata >> {ofs, 3'b000};

  always_comb begin
    case (size)
      SZ_B:    result = {{(XLEN-8){~unsgn & shifted[7]}}, shifted[7:0]};
      SZ_H:    result = {{(XLEN-16){~unsgn & shifted[15]}}, shifted[15:0]};
      default: result = shifted;
    endcase
  end
endmodule

// File: rtl/pinc_postinc_lsu.sv
module pinc_postinc_lsu
  import pinc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_instr,
  input  logic [XLEN-1:0]  in_base,
  input  logic [XLEN-1:0]  in_offs,
  input  logic [XLEN-1:0]  in_sdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [XLEN-1:0]  req_addr,
  output logic             req_we,
  output logic [NBYTE-1:0] req_be,
  output logic [XLEN-1:0]  req_wdata,
  input  logic             rsp_valid,
  input  logic [XLEN-1:0]  rsp_rdata,
  output logic             wb_data_en,
  output logic [REGW-1:0]  wb_data_reg,
  output logic [XLEN-1:0]  wb_data_val,
  output logic             wb_addr_en,
  output logic [REGW-1:0]  wb_addr_reg,
  output logic [XLEN-1:0]  wb_addr_val,
  output logic             busy,
  output logic             err
);
  dec_t             dec;
  logic [NBYTE-1:0] lane_be;
  logic [XLEN-1:0]  lane_wdata;
  logic             lane_misal;
  logic [XLEN-1:0]  next_base;
  logic [XLEN-1:0]  ld_result;

  fsm_e             state;
  logic [XLEN-1:0]  q_addr;
  logic [NBYTE-1:0] q_be;
  logic [XLEN-1:0]  q_wdata;
  logic             q_we;
  acc_size_e        q_size;
  logic             q_unsgn;
  logic [REGW-1:0]  q_rd;
  logic [REGW-1:0]  q_rb;
  logic [XLEN-1:0]  q_newbase;

  pinc_decode u_dec (.instr(in_instr), .dec(dec));

  pinc_lane u_lane (
    .size (dec.size),
    .ofs  (in_base[LANEW-1:0]),
    .sdata(in_sdata),
    .be   (lane_be),
    .wdata(lane_wdata),
    .misal(lane_misal)
  );

  pinc_ldext u_ext (
    .rdata (rsp_rdata),
    .ofs   (q_addr[LANEW-1:0]),
    .size  (q_size),
    .unsgn (q_unsgn),
    .result(ld_result)
  );

  assign next_base = in_base + (dec.use_reg ? in_offs : dec.imm);

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign req_valid = (state == ST_REQ);
  assign req_addr  = q_addr;
  assign req_we    = q_we;
  assign req_be    = q_be;
  assign req_wdata = q_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      q_addr      <= '0;
      q_be        <= '0;
      q_wdata     <= '0;
      q_we        <= 1'b0;
      q_size      <= SZ_B;
      q_unsgn     <= 1'b0;
      q_rd        <= '0;
      q_rb        <= '0;
      q_newbase   <= '0;
      err         <= 1'b0;
      wb_data_en  <= 1'b0;
      wb_data_reg <= '0;
      wb_data_val <= '0;
      wb_addr_en  <= 1'b0;
      wb_addr_reg <= '0;
      wb_addr_val <= '0;
    end else begin
      err        <= 1'b0;
      wb_data_en <= 1'b0;
      wb_addr_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            if (!dec.legal || lane_misal) begin
              err <= 1'b1;
            end else begin
              q_addr    <= in_base;
              q_be      <= lane_be;
              q_wdata   <= lane_wdata;
              q_we      <= dec.store;
              q_size    <= dec.size;
              q_unsgn   <= dec.unsgn;
              q_rd      <= dec.rd;
              q_rb      <= dec.rb;
              q_newbase <= next_base;
              state     <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            wb_addr_reg <= q_rb;
            wb_addr_val <= q_newbase;
            if (q_we) begin
              wb_addr_en <= 1'b1;
            end else begin
              wb_data_en  <= 1'b1;
              wb_data_reg <= q_rd;
              wb_data_val <= ld_result;
              wb_addr_en  <= (q_rd != q_rb);
            end
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pinc_postinc_lsu_chk.sv
module pinc_postinc_lsu_chk
  import pinc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [XLEN-1:0]  req_addr,
  input logic             req_we,
  input logic [NBYTE-1:0] req_be,
  input logic [XLEN-1:0]  req_wdata,
  input logic             wb_data_en,
  input logic [REGW-1:0]  wb_data_reg,
  input logic             wb_addr_en,
  input logic [REGW-1:0]  wb_addr_reg,
  input logic             busy,
  input logic             err
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_be)
                                 && $stable(req_we) && $stable(req_wdata));

  a_r11_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  a_r11_wb_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_data_en || wb_addr_en) |-> !busy);

  a_r11_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_addr_en |=> !wb_addr_en);

  a_r9_no_dual_same: assert property (@(posedge clk) disable iff (!rst_n)
    wb_data_en && wb_addr_en |-> wb_data_reg != wb_addr_reg);

  a_r6_be_width: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(req_be) == 1 || $countones(req_be) == 2 || $countones(req_be) == 4));

  a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && $countones(req_be) == 4 |-> req_addr[1:0] == 2'b00);

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !req_valid && !wb_data_en && !wb_addr_en && !busy);
endmodule

bind pinc_postinc_lsu pinc_postinc_lsu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
  .wb_data_en(wb_data_en), .wb_data_reg(wb_data_reg), .wb_addr_en(wb_addr_en),
  .wb_addr_reg(wb_addr_reg), .busy(busy), .err(err)
);

// File: tb/pinc_postinc_lsu_tb_top.sv
`timescale 1ns/1ps
module pinc_postinc_lsu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0, in_base = '0, in_offs = '0, in_sdata = '0;
  logic        req_valid, req_we;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic        wb_data_en, wb_addr_en, busy, err;
  logic [4:0]  wb_data_reg, wb_addr_reg;
  logic [31:0] wb_data_val, wb_addr_val;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [64];

  // reference decode results
  bit          r_legal, r_store, r_uns, r_usereg;
  int          r_bytes;
  logic [4:0]  r_rd, r_rb;
  logic [31:0] r_imm;

  always #2.5 clk = ~clk;

  pinc_postinc_lsu dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_li(logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1, logic [11:0] imm);
    return {imm, rs1, f3, rd, 7'b0001011};
  endfunction
  function automatic logic [31:0] enc_lr(logic [6:0] f7, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {f7, rs2, rs1, 3'b011, rd, 7'b0101011};
  endfunction
  function automatic logic [31:0] enc_si(logic [2:0] f3, logic [4:0] rs2, logic [4:0] rs1, logic [11:0] imm);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0101011};
  endfunction
  function automatic logic [31:0] enc_sr(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1, logic [4:0] rs3);
    return {f7, rs2, rs1, 3'b011, rs3, 7'b0101011};
  endfunction

  task automatic ref_decode(logic [31:0] ins);
    logic [11:0] i12;
    r_legal = 1; r_store = 0; r_uns = 0; r_usereg = 0; r_bytes = 1;
    r_rd = ins[11:7]; r_rb = ins[19:15]; r_imm = '0;
    if (ins[6:0] == 7'b0001011) begin
      i12 = ins[31:20];
      r_imm = {{20{i12[11]}}, i12};
      case (ins[14:12])
        3'b000: r_bytes = 1;
        3'b100: begin r_bytes = 1; r_uns = 1; end
        3'b001: r_bytes = 2;
        3'b101: begin r_bytes = 2; r_uns = 1; end
        3'b010: r_bytes = 4;
        default: r_legal = 0;
      endcase
    end else if (ins[6:0] == 7'b0101011 && ins[14:12] == 3'b011) begin
      r_usereg = 1;
      case (ins[31:25])
        7'b0000000: r_bytes = 1;
        7'b0001000: begin r_bytes = 1; r_uns = 1; end
        7'b0000001: r_bytes = 2;
        7'b0001001: begin r_bytes = 2; r_uns = 1; end
        7'b0000010: r_bytes = 4;
        7'b0010000: begin r_bytes = 1; r_store = 1; end
        7'b0010001: begin r_bytes = 2; r_store = 1; end
        7'b0010010: begin r_bytes = 4; r_store = 1; end
        default: r_legal = 0;
      endcase
    end else if (ins[6:0] == 7'b0101011) begin
      i12 = {ins[31:25], ins[11:7]};
      r_imm = {{20{i12[11]}}, i12};
      r_store = 1;
      case (ins[14:12])
        3'b000: r_bytes = 1;
        3'b001: r_bytes = 2;
        3'b010: r_bytes = 4;
        default: r_legal = 0;
      endcase
    end else begin
      r_legal = 0;
    end
  endtask

  task automatic run_op(string tag, logic [31:0] ins, logic [31:0] base, logic [31:0] offs,
                        logic [31:0] sdata, int rdy_wait, int lat);
    int          ofs, idx;
    logic [3:0]  ebe;
    logic [31:0] word, sh, eval, nbase, mask, ewd;
    ref_decode(ins);
    ofs   = int'(base[1:0]);
    idx   = int'(base[7:2]);
    nbase = base + (r_usereg ? offs : r_imm);
    ebe   = '0;
    for (int b = 0; b < 4; b++) if (b >= ofs && b < ofs + r_bytes) ebe[b] = 1'b1;
    @(negedge clk);
    chk({tag, " R11 in_ready idle"}, {31'b0, in_ready}, 32'd1);
    in_valid = 1; in_instr = ins; in_base = base; in_offs = offs; in_sdata = sdata;
    @(negedge clk);
    in_valid = 0;
    if (!r_legal || (ofs % r_bytes) != 0) begin
      chk({tag, " R10 err pulse"}, {31'b0, err}, 32'd1);
      chk({tag, " R10 no request"}, {30'b0, req_valid, busy}, 32'd0);
      @(negedge clk);
      chk({tag, " R10 err single, no wb"}, {29'b0, err, wb_data_en, wb_addr_en}, 32'd0);
      return;
    end
    chk({tag, " R11 req_valid/busy"}, {30'b0, req_valid, busy}, 32'd3);
    chk({tag, " R11 in_ready low"}, {31'b0, in_ready}, 32'd0);
    chk({tag, " R6 req_addr"}, req_addr, base);
    chk({tag, " R6 req_we"}, {31'b0, req_we}, {31'b0, r_store});
    chk({tag, " R6 req_be"}, {28'b0, req_be}, {28'b0, ebe});
    if (r_store) begin
      mask = '0; ewd = '0;
      for (int b = 0; b < 4; b++) if (ebe[b]) begin
        mask[8*b +: 8] = 8'hFF;
        ewd[8*b +: 8] = sdata[8*(b-ofs) +: 8];
      end
      chk({tag, " R6 req_wdata lanes"}, req_wdata & mask, ewd);
    end
    for (int w = 0; w < rdy_wait; w++) begin
      @(negedge clk);
      chk({tag, " R11 req held"}, {req_valid, req_be, req_addr[26:0]}, {1'b1, ebe, base[26:0]});
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk({tag, " R11 req dropped"}, {31'b0, req_valid}, 32'd0);
    if (r_store) begin
      for (int b = 0; b < 4; b++) if (ebe[b]) mem[idx][8*b +: 8] = sdata[8*(b-ofs) +: 8];
    end
    word = mem[idx];
    for (int w = 0; w < lat; w++) begin
      @(negedge clk);
      chk({tag, " R11 no early wb"}, {29'b0, busy, wb_data_en, wb_addr_en}, 32'd4);
    end
    rsp_valid = 1; rsp_rdata = r_store ? 32'hA5A5_5A5A : word;
    @(negedge clk);
    rsp_valid = 0;
    sh = word >> (8 * ofs);
    if (r_bytes == 1)      eval = r_uns ? {24'b0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
    else if (r_bytes == 2) eval = r_uns ? {16'b0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
    else                   eval = sh;
    chk({tag, " R11 idle at wb"}, {31'b0, busy}, 32'd0);
    if (r_store) begin
      chk({tag, " R5 store: no data wb"}, {31'b0, wb_data_en}, 32'd0);
      chk({tag, " R8 addr wb en"}, {31'b0, wb_addr_en}, 32'd1);
    end else begin
      chk({tag, " R7 load value"}, wb_data_val, eval);
      chk({tag, " R8 data wb en/reg"}, {26'b0, wb_data_en, wb_data_reg}, {26'b0, 1'b1, r_rd});
      chk({tag, " R9 addr wb en"}, {31'b0, wb_addr_en}, {31'b0, r_rd != r_rb});
    end
    if (wb_addr_en) begin
      chk({tag, " R8 addr wb reg"}, {27'b0, wb_addr_reg}, {27'b0, r_rb});
      chk({tag, " R8 addr wb val"}, wb_addr_val, nbase);
    end
    @(negedge clk);
    chk({tag, " R11 wb single cycle"}, {30'b0, wb_data_en, wb_addr_en}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h8F7E_41B2 + i * 32'h0103_0507;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'b0, busy, req_valid, err, wb_data_en, wb_addr_en}, 32'd0);
    chk("R1 reset in_ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1;
    // immediate loads
    run_op("R2 lb",  enc_li(3'b000, 5'd3, 5'd4, 12'hFFC), 32'h11, 0, 0, 0, 0);
    run_op("R2 lbu", enc_li(3'b100, 5'd5, 5'd6, 12'h008), 32'h23, 0, 0, 1, 2);
    run_op("R2 lh",  enc_li(3'b001, 5'd7, 5'd8, 12'h7FF), 32'h32, 0, 0, 0, 1);
    run_op("R2 lhu", enc_li(3'b101, 5'd9, 5'd10, 12'h800), 32'h40, 0, 0, 0, 0);
    run_op("R2 lw",  enc_li(3'b010, 5'd11, 5'd12, 12'h004), 32'h54, 0, 0, 2, 0);
    // register-offset loads
    run_op("R3 lb",  enc_lr(7'b0000000, 5'd1, 5'd2, 5'd3), 32'h63, 32'hFFFF_FFF0, 0, 0, 0);
    run_op("R3 lbu", enc_lr(7'b0001000, 5'd1, 5'd2, 5'd3), 32'h62, 32'd100, 0, 0, 1);
    run_op("R3 lh",  enc_lr(7'b0000001, 5'd13, 5'd14, 5'd3), 32'h76, 32'h1000, 0, 1, 0);
    run_op("R3 lhu", enc_lr(7'b0001001, 5'd15, 5'd16, 5'd3), 32'h84, 32'd2, 0, 0, 0);
    run_op("R3 lw",  enc_lr(7'b0000010, 5'd17, 5'd18, 5'd3), 32'h98, 32'h8000_0000, 0, 0, 0);
    // destination equals base
    run_op("R9 imm", enc_li(3'b010, 5'd20, 5'd20, 12'h010), 32'hA0, 0, 0, 0, 0);
    run_op("R9 reg", enc_lr(7'b0001000, 5'd21, 5'd21, 5'd2), 32'hA7, 32'd4, 0, 0, 0);
    // immediate stores, split offset
    run_op("R4 sb",  enc_si(3'b000, 5'd2, 5'd22, 12'hFE1), 32'hB3, 0, 32'h0000_00C7, 0, 0);
    run_op("R4 sh",  enc_si(3'b001, 5'd2, 5'd23, 12'h3A5), 32'hC2, 0, 32'h0000_9ABC, 1, 1);
    run_op("R4 sw",  enc_si(3'b010, 5'd2, 5'd24, 12'h81F), 32'hD0, 0, 32'hDEAD_BEEF, 0, 0);
    // register-offset stores: bits 11:7 name the offset register only
    run_op("R5 sb",  enc_sr(7'b0010000, 5'd2, 5'd25, 5'd9), 32'hE1, 32'd3, 32'h0000_0055, 0, 0);
    run_op("R5 sh",  enc_sr(7'b0010001, 5'd2, 5'd26, 5'd25), 32'hE6, 32'hFFFF_FF00, 32'h0000_F00D, 0, 0);
    run_op("R5 sw",  enc_sr(7'b0010010, 5'd2, 5'd27, 5'd27), 32'hEC, 32'd8, 32'h1234_5678, 0, 2);
    // read back stored data (R6/R7 lane consistency)
    run_op("R7 lb back", enc_li(3'b000, 5'd1, 5'd2, 12'h0), 32'hB3, 0, 0, 0, 0);
    run_op("R7 lh back", enc_li(3'b001, 5'd1, 5'd2, 12'h0), 32'hE6, 0, 0, 0, 0);
    run_op("R7 lw back", enc_li(3'b010, 5'd1, 5'd2, 12'h0), 32'hD0, 0, 0, 0, 0);
    // rejected instructions
    run_op("R10 lh mis", enc_li(3'b001, 5'd1, 5'd2, 12'h0), 32'h41, 0, 0, 0, 0);
    run_op("R10 lw mis", enc_lr(7'b0000010, 5'd1, 5'd2, 5'd3), 32'h42, 4, 0, 0, 0);
    run_op("R10 sw mis", enc_si(3'b010, 5'd1, 5'd2, 12'h0), 32'h43, 0, 0, 0, 0);
    run_op("R10 bad f3", enc_li(3'b111, 5'd1, 5'd2, 12'h0), 32'h40, 0, 0, 0, 0);
    run_op("R10 bad f7", enc_lr(7'b0000011, 5'd1, 5'd2, 5'd3), 32'h40, 0, 0, 0, 0);
    run_op("R10 bad f7s", enc_sr(7'b0010011, 5'd1, 5'd2, 5'd3), 32'h40, 0, 0, 0, 0);
    run_op("R10 bad opc", 32'h0000_0033, 32'h40, 0, 0, 0, 0);
    // long back-pressure and response delay
    run_op("R11 stall", enc_lr(7'b0000001, 5'd6, 5'd7, 5'd8), 32'h16, 32'd6, 0, 5, 6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule